// File: doc/BRIEF.md
# Card Command Issue and Response Capture

This block starts one command on a memory-card command path and keeps the card's reply. A host write supplies an 11-bit command word and a 32-bit argument. The command word carries a 6-bit index, a flag saying a reply is expected, a flag asking for a long reply, two mode flags that are only stored, and a start bit. A write that has the start bit set, made while the block is idle, sends the index and argument to the card side with a one-cycle request pulse.

The card side is a parallel byte handshake. It delivers reply bytes one at a time and marks the end of the reply with an end strobe, which may come with the last byte or on its own when there is no reply. The block checks the reply length against the flags. It packs a good reply most-significant byte first into four 32-bit response words and sets a completion flag. A wrong length sets a timeout flag, and so does a card that stays silent for a parameter-set number of cycles.

Top module: `card_cmd_issuer`

## Requirements
- R1: A write with command-word bit 10 (start) set, made while idle, is accepted. In the next cycle `card_req` is high for exactly one cycle, `card_index` shows command bits [5:0] and `card_arg` shows the written argument.
- R2: `status` bit 11 (busy) is high from the cycle after acceptance until completion. Command writes made while busy are ignored: the stored command word and argument stay the same, and no new request is issued.
- R3: At completion, by success or by timeout, bit 10 of the stored command word returns to 0. All its other bits keep their written values.
- R4: With bit 6 (reply expected) clear, the command completes on the end strobe whatever bytes arrived. It sets `status` bit 7 and leaves the response words unchanged.
- R5: With bit 6 set, bit 7 (long) clear and exactly 4 reply bytes, response word 0 is the bytes in arrival order with the first byte in bits [31:24]. Words 1 to 3 become zero and `status` bit 6 is set.
- R6: With bit 6 set and exactly 16 reply bytes, whatever bit 7 holds, words 0 to 3 each take four bytes in arrival order, first byte most significant. Bit 0 of word 3 is forced to 0 and `status` bit 6 is set.
- R7: With bit 6 set, each of these is a timeout: a reply of 0 bytes, a reply of 4 bytes with bit 7 set, and any length other than 4 or 16. A timeout sets `status` bit 2 and leaves all response words unchanged.
- R8: When busy, if TIMEOUT_CYC cycles in a row pass with neither a reply byte nor an end strobe, the command completes as a timeout (`status` bit 2) at the end of the last of those cycles.
- R9: Accepting a command clears `status` bits 2, 6 and 7. A command write with bit 10 clear, made while idle, only stores the word and argument: no request is issued and the status flags are kept.
- R10: After reset, `status`, the stored command word, the argument, all response words and `card_req` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_wdata | input | 11 | Command word: [5:0] index, 6 reply expected, 7 long, 8 and 9 stored mode flags, 10 start |
| arg_wdata | input | 32 | Argument written together with the command word |
| cmd_rdata | output | 11 | Stored command word |
| status | output | 12 | Bit 2 timeout, 6 reply received, 7 sent without reply, 11 busy; other bits zero |
| resp0 | output | 32 | Response word 0 |
| resp1 | output | 32 | Response word 1 |
| resp2 | output | 32 | Response word 2 |
| resp3 | output | 32 | Response word 3 |
| card_req | output | 1 | One-cycle command request to the card side |
| card_index | output | 6 | Command index to the card side |
| card_arg | output | 32 | Command argument to the card side |
| card_byte_valid | input | 1 | A reply byte is present on `card_byte` |
| card_byte | input | 8 | Reply byte |
| card_end | input | 1 | End of reply; may coincide with the last byte |

## Verification
A wrong byte counter shows up at once at completion: the wrong flag among bits 2, 6 and 7 is set, or the response words change when they should not. A shifted packing index shows as byte-swapped or misplaced words in the same cycle that busy falls. A quiet-cycle counter that is off by one moves the fall of busy by one cycle, so the bench samples busy one cycle before the expected timeout and again at it. A command register that is not guarded while busy shows as a changed `card_index` or a second request pulse after the stray write.

// File: rtl/card_cmd_issuer.sv
module card_cmd_issuer #(
  parameter int TIMEOUT_CYC = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_wr,
  input  logic [10:0] cmd_wdata,
  input  logic [31:0] arg_wdata,
  output logic [10:0] cmd_rdata,
  output logic [11:0] status,
  output logic [31:0] resp0,
  output logic [31:0] resp1,
  output logic [31:0] resp2,
  output logic [31:0] resp3,
  output logic        card_req,
  output logic [5:0]  card_index,
  output logic [31:0] card_arg,
  input  logic        card_byte_valid,
  input  logic [7:0]  card_byte,
  input  logic        card_end
);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);
  localparam int MAXB = 17;

  logic [10:0]  cmd_q;
  logic [31:0]  arg_q;
  logic         busy, to_f, rsp_f, sent_f;
  logic [127:0] resp_q, shadow_q, shadow_n;
  logic [4:0]   cnt_q, cnt_n;
  logic [TW-1:0] quiet_q;

  wire start    = cmd_wr && !busy && cmd_wdata[10];
  wire activity = card_byte_valid || card_end;
  wire expire   = busy && !activity && (quiet_q == TW'(TIMEOUT_CYC - 1));
  wire finish   = busy && (card_end || expire);

  assign cnt_n = (card_byte_valid && cnt_q != 5'(MAXB)) ? cnt_q + 5'd1 : cnt_q;

  always_comb begin
    shadow_n = shadow_q;
    if (card_byte_valid && cnt_q < 5'd16)
      shadow_n[8*(15 - int'(cnt_q)) +: 8] = card_byte;
  end

  wire ok_short = cmd_q[6] && !cmd_q[7] && cnt_n == 5'd4;
  wire ok_long  = cmd_q[6] && cnt_n == 5'd16;
  wire good_rsp = card_end && (ok_short || ok_long);
  wire no_rsp   = card_end && !cmd_q[6];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q <= '0; arg_q <= '0; busy <= 1'b0; card_req <= 1'b0;
      to_f <= 1'b0; rsp_f <= 1'b0; sent_f <= 1'b0;
      resp_q <= '0; shadow_q <= '0; cnt_q <= '0; quiet_q <= '0;
    end else begin
      card_req <= start;
      if (cmd_wr && !busy) begin
        cmd_q <= cmd_wdata;
        arg_q <= arg_wdata;
      end
      if (start) begin
        busy <= 1'b1;
        to_f <= 1'b0; rsp_f <= 1'b0; sent_f <= 1'b0;
        cnt_q <= '0;
        quiet_q <= '0;
      end else if (busy) begin
        cnt_q    <= cnt_n;
        shadow_q <= shadow_n;
        quiet_q  <= activity ? '0 : quiet_q + TW'(1);
        if (finish) begin
          busy      <= 1'b0;
          cmd_q[10] <= 1'b0;
          if (no_rsp) sent_f <= 1'b1;
          else if (good_rsp) begin
            rsp_f <= 1'b1;
            if (ok_long) resp_q <= {shadow_n[127:1], 1'b0};
            else         resp_q <= {shadow_n[127:96], 96'b0};
          end else to_f <= 1'b1;
        end
      end
    end
  end

  assign cmd_rdata  = cmd_q;
  assign status     = {busy, 3'b000, sent_f, rsp_f, 3'b000, to_f, 2'b00};
  assign resp0      = resp_q[127:96];
  assign resp1      = resp_q[95:64];
  assign resp2      = resp_q[63:32];
  assign resp3      = resp_q[31:0];
  assign card_index = cmd_q[5:0];
  assign card_arg   = arg_q;
endmodule

// File: rtl/card_cmd_issuer_chk.sv
module card_cmd_issuer_chk #(
  parameter int TIMEOUT_CYC = 64
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_wr,
  input logic [10:0] cmd_wdata,
  input logic [10:0] cmd_rdata,
  input logic [11:0] status,
  input logic        card_req,
  input logic        card_byte_valid,
  input logic        card_end
);
  int quiet;
  wire busy = status[11];

  always_ff @(posedge clk) begin
    if (!rst_n || !busy || card_byte_valid || card_end) quiet <= 0;
    else quiet <= quiet + 1;
  end

  assert_start_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && !busy && cmd_wdata[10] |=> card_req && busy);

  assert_req_while_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    card_req |-> busy);

  assert_busy_write_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cmd_wr |=> cmd_rdata[9:0] == $past(cmd_rdata[9:0]) && !card_req);

  assert_start_cleared_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !cmd_rdata[10]);

  assert_quiet_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    quiet <= TIMEOUT_CYC);

  assert_one_outcome_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $countones({status[2], status[6], status[7]}) == 1);
endmodule

bind card_cmd_issuer card_cmd_issuer_chk #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
  .cmd_rdata(cmd_rdata), .status(status), .card_req(card_req),
  .card_byte_valid(card_byte_valid), .card_end(card_end)
);

// File: tb/sim_card_cmd_issuer.sv
module sim_card_cmd_issuer;
  localparam int TCLK = 10;
  localparam int TO   = 16;
  localparam int NV   = 8;

  localparam logic [10:0] V_CMD [NV] = '{11'h451, 11'h4C2, 11'h4C9, 11'h400,
                                         11'h448, 11'h443, 11'h444, 11'h451};
  localparam int          V_NB  [NV] = '{4, 16, 4, 0, 0, 7, 16, 4};
  localparam logic [7:0]  V_BASE[NV] = '{8'h30, 8'hA0, 8'h55, 8'h00,
                                         8'h00, 8'h01, 8'h12, 8'hF0};
  localparam logic [2:0]  V_FLG [NV] = '{3'b010, 3'b010, 3'b001, 3'b100,
                                         3'b001, 3'b001, 3'b010, 3'b010};
  localparam logic [31:0] V_R0  [NV] = '{32'h30313233, 32'hA0A1A2A3, 32'hA0A1A2A3, 32'hA0A1A2A3,
                                         32'hA0A1A2A3, 32'hA0A1A2A3, 32'h12131415, 32'hF0F1F2F3};
  localparam logic [31:0] V_R1  [NV] = '{32'h0, 32'hA4A5A6A7, 32'hA4A5A6A7, 32'hA4A5A6A7,
                                         32'hA4A5A6A7, 32'hA4A5A6A7, 32'h16171819, 32'h0};
  localparam logic [31:0] V_R2  [NV] = '{32'h0, 32'hA8A9AAAB, 32'hA8A9AAAB, 32'hA8A9AAAB,
                                         32'hA8A9AAAB, 32'hA8A9AAAB, 32'h1A1B1C1D, 32'h0};
  localparam logic [31:0] V_R3  [NV] = '{32'h0, 32'hACADAEAE, 32'hACADAEAE, 32'hACADAEAE,
                                         32'hACADAEAE, 32'hACADAEAE, 32'h1E1F2020, 32'h0};

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_wr = 1'b0;
  logic [10:0] cmd_wdata = '0;
  logic [31:0] arg_wdata = '0;
  logic [10:0] cmd_rdata;
  logic [11:0] status;
  logic [31:0] resp0, resp1, resp2, resp3, card_arg;
  logic card_req;
  logic [5:0] card_index;
  logic card_byte_valid = 1'b0, card_end = 1'b0;
  logic [7:0] card_byte = '0;
  int checks = 0, fails = 0;

  always #(TCLK/2) clk = ~clk;

  card_cmd_issuer #(.TIMEOUT_CYC(TO)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
    .arg_wdata(arg_wdata), .cmd_rdata(cmd_rdata), .status(status),
    .resp0(resp0), .resp1(resp1), .resp2(resp2), .resp3(resp3),
    .card_req(card_req), .card_index(card_index), .card_arg(card_arg),
    .card_byte_valid(card_byte_valid), .card_byte(card_byte), .card_end(card_end)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [10:0] c, input logic [31:0] a);
    cmd_wr = 1'b1; cmd_wdata = c; arg_wdata = a;
    @(negedge clk);
    cmd_wr = 1'b0;
  endtask

  task automatic send(input int n, input logic [7:0] base);
    if (n == 0) begin
      card_end = 1'b1;
      @(negedge clk);
    end else begin
      for (int k = 0; k < n; k++) begin
        card_byte_valid = 1'b1; card_byte = base + 8'(k); card_end = (k == n - 1);
        @(negedge clk);
      end
    end
    card_byte_valid = 1'b0; card_end = 1'b0;
  endtask

  task automatic chk_resp(input string req, input logic [31:0] a, input logic [31:0] b,
                          input logic [31:0] c, input logic [31:0] d);
    chk(req, resp0, a); chk(req, resp1, b); chk(req, resp2, c); chk(req, resp3, d);
  endtask

  initial begin
    #(TCLK * 20000);
    fails++;
    $display("FAIL watchdog: got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 status", 32'(status), 32'h0);
    chk("R10 cmd", 32'(cmd_rdata), 32'h0);
    chk("R10 req", 32'(card_req), 32'h0);
    chk("R10 arg", card_arg, 32'h0);
    chk_resp("R10 resp", 32'h0, 32'h0, 32'h0, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      issue(V_CMD[i], 32'hC0DE0000 + 32'(i));
      chk("R1 req", 32'(card_req), 32'h1);
      chk("R1 index", 32'(card_index), 32'(V_CMD[i][5:0]));
      chk("R1 arg", card_arg, 32'hC0DE0000 + 32'(i));
      chk("R2 busy", 32'(status[11]), 32'h1);
      chk("R9 flags cleared", 32'({status[7], status[6], status[2]}), 32'h0);
      send(V_NB[i], V_BASE[i]);
      chk("R4 R5 R6 R7 flags", 32'({status[7], status[6], status[2]}), 32'(V_FLG[i]));
      chk("R2 idle", 32'(status[11]), 32'h0);
      chk("R3 start cleared", 32'(cmd_rdata), 32'(V_CMD[i] & 11'h3FF));
      chk_resp("R5 R6 R7 resp", V_R0[i], V_R1[i], V_R2[i], V_R3[i]);
    end

    // R9: write without start while idle
    issue(11'h0C5, 32'h12345678);
    chk("R9 no req", 32'(card_req), 32'h0);
    chk("R9 stored", 32'(cmd_rdata), 32'h0C5);
    chk("R9 arg stored", card_arg, 32'h12345678);
    chk("R9 flags kept", 32'(status), 32'h040);

    // R8: silent card
    issue(11'h441, 32'hAAAA0001);
    repeat (TO - 1) @(negedge clk);
    chk("R8 still busy", 32'(status[11]), 32'h1);
    @(negedge clk);
    chk("R8 timeout", 32'(status), 32'h004);
    chk("R3 start cleared", 32'(cmd_rdata), 32'h041);
    chk_resp("R7 resp kept", 32'hF0F1F2F3, 32'h0, 32'h0, 32'h0);

    // R8: gaps shorter than the limit do not time out
    issue(11'h451, 32'hAAAA0002);
    for (int k = 0; k < 4; k++) begin
      repeat (TO - 2) @(negedge clk);
      card_byte_valid = 1'b1; card_byte = 8'h60 + 8'(k); card_end = (k == 3);
      @(negedge clk);
      card_byte_valid = 1'b0; card_end = 1'b0;
    end
    chk("R8 gaps ok", 32'(status), 32'h040);
    chk("R5 gaps resp", resp0, 32'h60616263);

    // R2: write while busy ignored
    issue(11'h445, 32'hBBBB0000);
    chk("R9 flags cleared", 32'(status), 32'h800);
    cmd_wr = 1'b1; cmd_wdata = 11'h47F; arg_wdata = 32'hDEADBEEF;
    @(negedge clk);
    cmd_wr = 1'b0;
    chk("R2 no second req", 32'(card_req), 32'h0);
    chk("R2 index kept", 32'(card_index), 32'h05);
    chk("R2 arg kept", card_arg, 32'hBBBB0000);
    send(4, 8'h70);
    chk("R2 cmd kept", 32'(cmd_rdata), 32'h045);
    chk("R5 resp", resp0, 32'h70717273);

    // R7: more than 16 bytes
    issue(11'h4C1, 32'h0);
    send(20, 8'h80);
    chk("R7 overlong", 32'(status), 32'h004);
    chk("R7 resp kept", resp0, 32'h70717273);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule